// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a 32-bit processor pipeline and a word-wide data memory whose addresses count bytes. Each request carries an opcode, a base register value and a 16-bit signed displacement. The block adds the sign-extended displacement to the base to form the byte address. It then issues a word-aligned memory access one cycle later. For a store, that access carries one write strobe per byte lane and the store data copied into every lane. For a load, the block raises a read and remembers which lanes the load wants.

Memory answers a read in the cycle after the read is issued. The block takes the returned word and picks out the addressed byte, halfword or word. It extends a byte or halfword to 32 bits with the sign or with zeros, as the opcode asks, and presents the result one cycle later.

Lanes are numbered big-endian: the byte at word offset 0 occupies data bits 31:24. Halfword and word accesses that do not sit on their natural boundary are not performed. Instead the block raises a misalignment pulse and issues neither strobes nor a read.

Top module: `lsu_lane_align`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries that address with bits 1:0 forced to zero, registered in the cycle after an accepted request.
- R2: The recognised opcodes are loads 32 (signed byte), 33 (signed half), 35 (word), 36 (unsigned byte) and 37 (unsigned half), and stores 40 (byte), 41 (half) and 43 (word). Any other opcode leaves `mem_wr`, `mem_rd` and `mem_misalign` low and changes no memory word.
- R3: Strobe bit i of `mem_be` enables data bits 8i+7:8i. A byte store at offset o enables only bit 3-o. A halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store enables all four bits. `mem_be` is zero whenever `mem_wr` is low.
- R4: `mem_wdata` holds the low byte of `req_wdata` copied four times for a byte store, the low halfword copied twice for a halfword store, and `req_wdata` unchanged for a word store.
- R5: When `mem_rvalid` is high in the cycle after `mem_rd`, `ld_valid` rises in the following cycle. The returned lanes are chosen big-endian: a byte at offset o comes from bits 8(3-o)+7:8(3-o), a halfword at offset 0 from bits 31:16 and at offset 2 from bits 15:0, and a word is the whole word.
- R6: Signed byte and halfword loads (opcodes 32, 33) fill the upper bits of `ld_data` with the most significant bit of the loaded value.
- R7: Unsigned byte and halfword loads (opcodes 36, 37) fill the upper bits of `ld_data` with zeros.
- R8: A halfword access with address bit 0 set, or a word access with address bits 1:0 nonzero, pulses `mem_misalign` for one cycle, keeps `mem_wr`, `mem_rd` and `mem_be` at zero, alters no memory word and produces no `ld_valid`.
- R9: While `rst_n` is low, `mem_wr`, `mem_rd`, `mem_misalign`, `mem_be`, `ld_valid` and `ld_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_opcode | input | 6 | Access opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store value, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wr | output | 1 | Memory write this cycle |
| mem_rd | output | 1 | Memory read this cycle |
| mem_be | output | 4 | Byte write strobes, bit i covers bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_misalign | output | 1 | Misaligned request pulse |
| mem_rvalid | input | 1 | Read data valid, one cycle after `mem_rd` |
| mem_rdata | input | 32 | Word returned by memory |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Some properties are checked by assertions on every cycle:
- at most one of write, read or misalignment fires;
- issued addresses are word aligned;
- strobes form a one-, two- or four-lane set and are quiet without a write;
- a misalignment pulse comes with no memory action;
- one-lane stores carry the same byte in every lane;
- a load result only follows returned data;
- byte results carry the correct sign or zero fill.

Other behaviours only the bench scenarios can show, because they depend on the values the block was given:
- the exact lane picked for each offset;
- the address sum with a negative displacement;
- the content written by partial stores, read back through later word loads;
- memory left untouched after misaligned or unknown requests.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } acc_sz_e;

  typedef struct packed {
    logic    ok;
    logic    is_st;
    logic    zext;
    acc_sz_e sz;
  } op_dec_t;

  localparam logic [OP_W-1:0] OP_LD_B  = 6'd32;
  localparam logic [OP_W-1:0] OP_LD_H  = 6'd33;
  localparam logic [OP_W-1:0] OP_LD_W  = 6'd35;
  localparam logic [OP_W-1:0] OP_LD_BU = 6'd36;
  localparam logic [OP_W-1:0] OP_LD_HU = 6'd37;
  localparam logic [OP_W-1:0] OP_ST_B  = 6'd40;
  localparam logic [OP_W-1:0] OP_ST_H  = 6'd41;
  localparam logic [OP_W-1:0] OP_ST_W  = 6'd43;

  // Opcode to access attributes; unknown codes come back with ok = 0.
  function automatic op_dec_t f_decode(input logic [OP_W-1:0] op);
    op_dec_t d;
    d = '{ok: 1'b0, is_st: 1'b0, zext: 1'b0, sz: SZ_B};
    case (op)
      OP_LD_B:  d = '{ok: 1'b1, is_st: 1'b0, zext: 1'b0, sz: SZ_B};
      OP_LD_H:  d = '{ok: 1'b1, is_st: 1'b0, zext: 1'b0, sz: SZ_H};
      OP_LD_W:  d = '{ok: 1'b1, is_st: 1'b0, zext: 1'b0, sz: SZ_W};
      OP_LD_BU: d = '{ok: 1'b1, is_st: 1'b0, zext: 1'b1, sz: SZ_B};
      OP_LD_HU: d = '{ok: 1'b1, is_st: 1'b0, zext: 1'b1, sz: SZ_H};
      OP_ST_B:  d = '{ok: 1'b1, is_st: 1'b1, zext: 1'b0, sz: SZ_B};
      OP_ST_H:  d = '{ok: 1'b1, is_st: 1'b1, zext: 1'b0, sz: SZ_H};
      OP_ST_W:  d = '{ok: 1'b1, is_st: 1'b1, zext: 1'b0, sz: SZ_W};
      default:  d = '{ok: 1'b0, is_st: 1'b0, zext: 1'b0, sz: SZ_B};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
  import lsu_lane_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output op_dec_t         dec
);

  assign dec = f_decode(opcode);

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16,
  parameter int LANES  = 4,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_sz_e           sz,
  output logic [ADDR_W-1:0] word_addr,
  output logic [OFF_W-1:0]  lane_off,
  output logic              misaligned
);

  logic [ADDR_W-1:0] ea;
  logic [OFF_W:0]    span;
  logic [OFF_W-1:0]  size_mask;

  assign ea        = base + {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
  assign word_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign lane_off  = ea[OFF_W-1:0];

  // Access length in bytes, and the offset bits that must be zero for it.
  assign span       = (OFF_W+1)'(1) << sz;
  assign size_mask  = OFF_W'(span - 1'b1);
  assign misaligned = |(lane_off & size_mask);

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_sz_e           sz,
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lanes_data
);

  logic [OFF_W:0]   span;
  logic [OFF_W-1:0] size_mask;

  assign span      = (OFF_W+1)'(1) << sz;
  assign size_mask = OFF_W'(span - 1'b1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // Big-endian: lane i holds the byte at word offset LANES-1-i.
    localparam logic [OFF_W-1:0] LOFS = OFF_W'(LANES - 1 - i);
    logic [OFF_W:0]   rel;
    logic             hit;
    logic [OFF_W-1:0] src_idx;

    always_comb begin
      rel     = {1'b0, LOFS} - {1'b0, lane_off};
      hit     = !rel[OFF_W] && (rel < span);
      src_idx = size_mask - (LOFS & size_mask);
    end

    assign be[i]              = hit;
    assign lanes_data[8*i +: 8] = wdata[{src_idx, 3'b000} +: 8];
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_sz_e           sz,
  input  logic              zext,
  input  logic [OFF_W-1:0]  lane_off,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);

  logic [OFF_W:0]   span;
  logic [OFF_W-1:0] size_mask;
  logic [OFF_W-1:0] top_lane;
  logic             fill;

  assign span      = (OFF_W+1)'(1) << sz;
  assign size_mask = OFF_W'(span - 1'b1);
  // The first byte of the access is its most significant one.
  assign top_lane  = OFF_W'(LANES - 1) - lane_off;
  assign fill      = zext ? 1'b0 : rdata[{top_lane, 3'b111}];

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    localparam logic [OFF_W-1:0] KI = OFF_W'(k);
    logic [OFF_W-1:0] src_ofs;
    logic [OFF_W-1:0] src_lane;
    logic             in_acc;

    always_comb begin
      src_ofs  = lane_off + (size_mask - KI);
      src_lane = OFF_W'(LANES - 1) - src_ofs;
      in_acc   = ({1'b0, KI} < span);
    end

    assign data[8*k +: 8] = in_acc ? rdata[{src_lane, 3'b000} +: 8] : {8{fill}};
  end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [OP_W-1:0]       req_opcode,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [OFS_W-1:0]      req_offset,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_wr,
  output logic                  mem_rd,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  mem_misalign,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ld_valid,
  output logic [DATA_W-1:0]     ld_data
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  op_dec_t           dec;
  logic [ADDR_W-1:0] word_addr;
  logic [OFF_W-1:0]  lane_off;
  logic              misaligned;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_lanes;
  logic [DATA_W-1:0] ext_data;

  // Stage 1 holds the lane details of an issued load; stage 2 waits for data.
  acc_sz_e           s1_sz, pend_sz, ld_sz_q;
  logic              s1_zext, pend_zext, ld_zext_q;
  logic [OFF_W-1:0]  s1_off, pend_off;
  logic              pend_valid;

  lsu_op_decode u_dec (
    .opcode (req_opcode),
    .dec    (dec)
  );

  lsu_addr_gen #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .LANES  (LANES)
  ) u_agen (
    .base       (req_base),
    .ofs        (req_offset),
    .sz         (dec.sz),
    .word_addr  (word_addr),
    .lane_off   (lane_off),
    .misaligned (misaligned)
  );

  lsu_store_lanes #(
    .DATA_W (DATA_W)
  ) u_st (
    .sz         (dec.sz),
    .lane_off   (lane_off),
    .wdata      (req_wdata),
    .be         (st_be),
    .lanes_data (st_lanes)
  );

  lsu_load_extract #(
    .DATA_W (DATA_W)
  ) u_ld (
    .sz       (pend_sz),
    .zext     (pend_zext),
    .lane_off (pend_off),
    .rdata    (mem_rdata),
    .data     (ext_data)
  );

  // Named events for the checker and for reading the pipeline.
  logic acc_go, evt_store_issue, evt_load_issue, evt_misalign, evt_load_done;
  assign acc_go          = req_valid & dec.ok;
  assign evt_misalign    = acc_go & misaligned;
  assign evt_store_issue = acc_go & ~misaligned & dec.is_st;
  assign evt_load_issue  = acc_go & ~misaligned & ~dec.is_st;
  assign evt_load_done   = mem_rvalid & pend_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr     <= '0;
      mem_wr       <= 1'b0;
      mem_rd       <= 1'b0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      mem_misalign <= 1'b0;
      s1_sz        <= SZ_B;
      s1_zext      <= 1'b0;
      s1_off       <= '0;
      pend_valid   <= 1'b0;
      pend_sz      <= SZ_B;
      pend_zext    <= 1'b0;
      pend_off     <= '0;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
      ld_sz_q      <= SZ_B;
      ld_zext_q    <= 1'b0;
    end else begin
      mem_wr       <= evt_store_issue;
      mem_rd       <= evt_load_issue;
      mem_misalign <= evt_misalign;
      mem_be       <= evt_store_issue ? st_be : '0;
      if (acc_go) mem_addr <= word_addr;
      if (evt_store_issue) mem_wdata <= st_lanes;
      if (evt_load_issue) begin
        s1_sz   <= dec.sz;
        s1_zext <= dec.zext;
        s1_off  <= lane_off;
      end
      pend_valid <= mem_rd;
      pend_sz    <= s1_sz;
      pend_zext  <= s1_zext;
      pend_off   <= s1_off;
      ld_valid   <= evt_load_done;
      if (evt_load_done) begin
        ld_data   <= ext_data;
        ld_sz_q   <= pend_sz;
        ld_zext_q <= pend_zext;
      end
    end
  end

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_wr,
  input logic              mem_rd,
  input logic              mem_misalign,
  input logic [OFF_W-1:0]  addr_lo,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rvalid,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data,
  input logic [1:0]        ld_sz_q,
  input logic              ld_zext_q
);

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, mem_rd, mem_misalign}));

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> (addr_lo == '0));

  // R3
  strobe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                $countones(mem_be) == LANES));

  // R3
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |-> (mem_be == '0));

  // R4
  byte_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $countones(mem_be) == 1) |-> (mem_wdata == {LANES{mem_wdata[7:0]}}));

  // R8
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_misalign |-> (!mem_wr && !mem_rd && mem_be == '0));

  // R5
  result_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_rvalid));

  // R7
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_zext_q && ld_sz_q == 2'd0) |-> (ld_data[DATA_W-1:8] == '0));

  // R6
  byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_zext_q && ld_sz_q == 2'd0) |->
      (ld_data[DATA_W-1:7] == '0 || ld_data[DATA_W-1:7] == '1));

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_wr       (mem_wr),
  .mem_rd       (mem_rd),
  .mem_misalign (mem_misalign),
  .addr_lo      (mem_addr[OFF_W-1:0]),
  .mem_be       (mem_be),
  .mem_wdata    (mem_wdata),
  .mem_rvalid   (mem_rvalid),
  .ld_valid     (ld_valid),
  .ld_data      (ld_data),
  .ld_sz_q      (ld_sz_q),
  .ld_zext_q    (ld_zext_q)
);

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_opcode = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic        mem_wr, mem_rd, mem_misalign;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;

  always #2 clk = ~clk;

  lsu_lane_align u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_misalign(mem_misalign), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Memory model, answering a read in the cycle after it sees it.
  logic [31:0] mem_arr [16];
  logic [31:0] ref_mem [16];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= mem_rd;
      if (mem_rd) mem_rdata <= mem_arr[mem_addr[5:2]];
      if (mem_wr)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem_arr[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  typedef struct {
    bit          wr, rd, mis;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  typedef struct {
    logic [31:0] v;
    string       tag;
  } ld_exp_t;

  exp_t    mq[$];
  ld_exp_t lq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ld_ref(input logic [5:0] op, input logic [31:0] w,
                                          input logic [1:0] off);
    logic [31:0] t;
    t = w << (8 * off);
    case (op)
      6'd32:   return {{24{t[31]}}, t[31:24]};
      6'd36:   return {24'h0, t[31:24]};
      6'd33:   return {{16{t[31]}}, t[31:16]};
      6'd37:   return {16'h0, t[31:16]};
      default: return w;
    endcase
  endfunction

  // Driver: computes the expected outcome and queues it, then drives the request.
  task automatic issue(input logic [5:0] op, input logic [31:0] base,
                       input logic [15:0] ofs, input logic [31:0] wd, input string tag);
    logic [31:0] ea;
    logic [1:0]  off;
    logic [3:0]  idx;
    int          nb;
    bit          st, known;
    exp_t        e;
    ea  = base + {{16{ofs[15]}}, ofs};
    off = ea[1:0];
    idx = ea[5:2];
    known = 1; st = 0; nb = 4;
    case (op)
      6'd32, 6'd36: nb = 1;
      6'd33, 6'd37: nb = 2;
      6'd35:        nb = 4;
      6'd40: begin nb = 1; st = 1; end
      6'd41: begin nb = 2; st = 1; end
      6'd43: begin nb = 4; st = 1; end
      default: known = 0;
    endcase
    e.wr = 0; e.rd = 0; e.mis = 0; e.addr = {ea[31:2], 2'b00}; e.be = 4'h0;
    e.wd = 32'h0; e.tag = tag;
    if (known) begin
      if ((nb == 2 && off[0]) || (nb == 4 && off != 2'd0)) begin
        e.mis = 1;
      end else if (st) begin
        e.wr = 1;
        case (nb)
          1: begin
            e.be = 4'b1000 >> off;
            e.wd = {4{wd[7:0]}};
            ref_mem[idx][8*(3-off) +: 8] = wd[7:0];
          end
          2: begin
            e.be = (off == 2'd0) ? 4'b1100 : 4'b0011;
            e.wd = {2{wd[15:0]}};
            if (off == 2'd0) ref_mem[idx][31:16] = wd[15:0];
            else             ref_mem[idx][15:0]  = wd[15:0];
          end
          default: begin
            e.be = 4'b1111;
            e.wd = wd;
            ref_mem[idx] = wd;
          end
        endcase
      end else begin
        e.rd = 1;
        lq.push_back('{v: ld_ref(op, ref_mem[idx], off), tag: tag});
      end
    end
    @(negedge clk);
    mq.push_back(e);
    req_valid  = 1'b1;
    req_opcode = op;
    req_base   = base;
    req_offset = ofs;
    req_wdata  = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: one compare per cycle, just after the edge.
  initial begin
    wait (rst_n);
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (mq.size() > 0) begin
        e = mq.pop_front();
        chk(mem_wr == e.wr, e.tag, "mem_wr", 32'(mem_wr), 32'(e.wr));
        chk(mem_rd == e.rd, e.tag, "mem_rd", 32'(mem_rd), 32'(e.rd));
        chk(mem_misalign == e.mis, e.tag, "mem_misalign", 32'(mem_misalign), 32'(e.mis));
        chk(mem_be == e.be, e.tag, "mem_be", 32'(mem_be), 32'(e.be));
        if (e.wr || e.rd) chk(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
        if (e.wr) chk(mem_wdata == e.wd, e.tag, "mem_wdata", mem_wdata, e.wd);
      end else if (mem_wr || mem_rd || mem_misalign) begin
        chk(1'b0, "R2", "spurious access", {29'h0, mem_wr, mem_rd, mem_misalign}, 32'h0);
      end
      if (ld_valid) begin
        if (lq.size() == 0) begin
          chk(1'b0, "R8", "unexpected ld_valid", ld_data, 32'h0);
        end else begin
          ld_exp_t l;
          l = lq.pop_front();
          chk(ld_data == l.v, l.tag, "ld_data", ld_data, l.v);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_arr[i] = 32'h9C5A_3E81 + 32'(i) * 32'h0102_0304;
      ref_mem[i] = mem_arr[i];
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(mem_wr == 1'b0 && mem_rd == 1'b0 && mem_misalign == 1'b0, "R9", "strobes in reset",
        {29'h0, mem_wr, mem_rd, mem_misalign}, 32'h0);
    chk(mem_be == 4'h0 && ld_valid == 1'b0, "R9", "be/ld_valid in reset",
        {27'h0, ld_valid, mem_be}, 32'h0);
    chk(ld_data == 32'h0, "R9", "ld_data in reset", ld_data, 32'h0);
    rst_n = 1'b1;

    // R1: address sum, positive and negative displacement
    issue(6'd35, 32'h0000_0040, 16'h0008, 32'h0, "R1");
    issue(6'd35, 32'h0000_0080, 16'hFFF8, 32'h0, "R1");
    // R5 R6 R7: every byte lane, both extensions, back to back
    for (int o = 0; o < 4; o++) issue(6'd32, 32'h0000_0010, 16'(o), 32'h0, "R5 R6");
    for (int o = 0; o < 4; o++) issue(6'd36, 32'h0000_0010, 16'(o), 32'h0, "R5 R7");
    issue(6'd33, 32'h0000_0010, 16'h0000, 32'h0, "R5 R6");
    issue(6'd33, 32'h0000_0010, 16'h0002, 32'h0, "R5 R6");
    issue(6'd37, 32'h0000_0010, 16'h0000, 32'h0, "R5 R7");
    issue(6'd37, 32'h0000_0010, 16'h0002, 32'h0, "R5 R7");
    issue(6'd33, 32'h0000_0014, 16'h0002, 32'h0, "R5 R6");
    idle(2);
    // R3 R4: byte stores in each lane, then read back the word
    issue(6'd40, 32'h0000_0020, 16'h0000, 32'h1234_56A7, "R3 R4");
    issue(6'd40, 32'h0000_0020, 16'h0001, 32'h1234_5602, "R3 R4");
    issue(6'd40, 32'h0000_0020, 16'h0002, 32'h1234_56F3, "R3 R4");
    issue(6'd40, 32'h0000_0020, 16'h0003, 32'h1234_5644, "R3 R4");
    issue(6'd35, 32'h0000_0020, 16'h0000, 32'h0, "R3");
    // halfword stores in both halves
    issue(6'd41, 32'h0000_0024, 16'h0000, 32'hAAAA_BEEF, "R3 R4");
    issue(6'd41, 32'h0000_0024, 16'h0002, 32'h1111_7F01, "R3 R4");
    issue(6'd35, 32'h0000_0024, 16'h0000, 32'h0, "R3");
    issue(6'd37, 32'h0000_0024, 16'h0000, 32'h0, "R7");
    issue(6'd33, 32'h0000_0024, 16'h0000, 32'h0, "R6");
    // word store
    issue(6'd43, 32'h0000_0030, 16'hFFF8, 32'hDEAD_C0DE, "R3 R4");
    issue(6'd35, 32'h0000_0028, 16'h0000, 32'h0, "R3");
    idle(2);
    // R8: misaligned halfword and word accesses
    issue(6'd33, 32'h0000_0031, 16'h0000, 32'h0, "R8");
    issue(6'd37, 32'h0000_0030, 16'h0003, 32'h0, "R8");
    issue(6'd35, 32'h0000_002A, 16'h0000, 32'h0, "R8");
    issue(6'd43, 32'h0000_0029, 16'h0000, 32'h5555_5555, "R8");
    issue(6'd41, 32'h0000_0027, 16'h0000, 32'h6666_6666, "R8");
    issue(6'd43, 32'h0000_002C, 16'hFFFE, 32'h7777_7777, "R8");
    issue(6'd35, 32'h0000_0028, 16'h0000, 32'h0, "R8");
    issue(6'd35, 32'h0000_0024, 16'h0000, 32'h0, "R8");
    // R2: unknown opcodes do nothing
    issue(6'd0,  32'h0000_002C, 16'h0000, 32'h0BAD_0BAD, "R2");
    issue(6'd34, 32'h0000_002C, 16'h0000, 32'h0BAD_0BAD, "R2");
    issue(6'd42, 32'h0000_002C, 16'h0000, 32'h0BAD_0BAD, "R2");
    issue(6'd35, 32'h0000_002C, 16'h0000, 32'h0, "R2");
    idle(6);
    chk(mq.size() == 0, "R1", "pending access items", 32'(mq.size()), 32'h0);
    chk(lq.size() == 0, "R5", "missing load results", 32'(lq.size()), 32'h0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R5 act=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule